// File: doc/BRIEF.md
# Keyboard Key-Press Decoder

This block sits behind the two open-collector lines of a standard PS/2 keyboard and runs entirely on the system clock. It samples the keyboard clock line, removes glitches from it and turns each clean falling edge into a one-cycle sampling event. The data line is brought into the same clock domain through its own synchronizer. A small receiver reassembles each serial frame into a byte. A classifier then sorts each byte into a prefix, a released key or a pressed key.

The decoder produces one valid pulse, carrying the scan code, for every key-press code that arrives. The release sequence is a prefix byte followed by a repeat of the key's code, and none of it produces a pulse. As a result, downstream logic receives each typed key once. The code is reported on the frame that carries it and is never held back until the next key arrives.

Top module: `kbd_keypress_decoder`

## Requirements
- R1: A low excursion of the keyboard clock line shorter than 8 system clocks has no effect. The filtered clock goes low only after 8 consecutive low samples and high only after 8 consecutive high samples.
- R2: A filtered falling edge that arrives while the receiver is idle starts a frame only if the data line is low (start bit). An edge with data high leaves the receiver idle.
- R3: After the start bit, the receiver takes the next 9 falling edges as 8 data bits (LSB first) and a parity bit. The edge after those is the stop bit, and it completes the frame. A byte that is neither 0xF0 nor 0xE0, and that follows no pending release marker, is reported on `key_code`.
- R4: `key_valid` is high for exactly one system clock for each reported byte. It rises within 16 system clocks of the stop-bit falling edge on the keyboard clock line. `key_code` changes only together with `key_valid`.
- R5: The byte 0xF0 is the release marker. It is never reported, and the next non-0xE0 byte after it is not reported either.
- R6: The byte 0xE0 is the extension prefix. It is never reported, it does not clear a pending release marker, and the byte after it is reported as normal.
- R7: A pending release marker is cleared once it has suppressed one byte, so a later code is reported again.
- R8: A make code repeated by a held key is reported each time it arrives.
- R9: Reset clears `key_valid` and `key_code` to 0 and discards a frame that is partly received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| kb_clk_in | input | 1 | Keyboard clock line, asynchronous |
| kb_dat_in | input | 1 | Keyboard data line, asynchronous |
| key_code | output | 8 | Scan code of the last reported key press |
| key_valid | output | 1 | One-cycle strobe marking a new key press |

## Verification
A fall on the keyboard clock line passes through two synchronizer flops, eight history samples and the filter register before the sampling event appears. The frame-done flag and the output strobe then add one cycle each. A press therefore shows up about 13 system clocks after the stop-bit edge, and the bench allows a window of 16. The bench counts system clocks since the most recent fall it drove and tests that count whenever it sees the strobe. It samples all outputs on the falling edge of the system clock. Codes it expects are queued before each frame is driven, so any strobe that finds an empty queue is an error. After each key sequence, the bench waits out the pipeline and then requires the queue to be empty, so a missing report is also caught.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] RELEASE_MARK = 8'hF0;
  localparam logic [CODE_W-1:0] EXTEND_MARK  = 8'hE0;

  typedef enum logic {FR_IDLE, FR_SHIFT} fr_state_t;

  typedef enum logic [1:0] {
    BYTE_KEY     = 2'd0,
    BYTE_RELEASE = 2'd1,
    BYTE_EXTEND  = 2'd2
  } byte_kind_t;

  function automatic byte_kind_t classify_byte(input logic [CODE_W-1:0] b);
    if (b == RELEASE_MARK)     return BYTE_RELEASE;
    else if (b == EXTEND_MARK) return BYTE_EXTEND;
    else                       return BYTE_KEY;
  endfunction

  function automatic logic odd_parity(input logic [CODE_W-1:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= RST_VAL;
        else     pipe[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= RST_VAL;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/kbd_clk_filter.sv
module kbd_clk_filter #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o,
  output logic fall_o
);
  logic [LEN-1:0] hist;
  logic           filt;
  logic           fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '1;
      filt <= 1'b1;
      fall <= 1'b0;
    end else begin
      hist <= {raw_i, hist[LEN-1:1]};
      fall <= 1'b0;
      if (&hist) begin
        filt <= 1'b1;
      end else if (hist == '0) begin
        filt <= 1'b0;
        fall <= filt;
      end
    end
  end

  assign filt_o = filt;
  assign fall_o = fall;
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_pkg::*;
#(
  parameter int PAYLOAD = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_i,
  input  logic              dat_i,
  output logic [CODE_W-1:0] byte_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(PAYLOAD + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAYLOAD);

  fr_state_t          st;
  logic [CNT_W-1:0]   cnt;
  logic [PAYLOAD-1:0] sreg;
  logic [CODE_W-1:0]  byte_q;
  logic               done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= FR_IDLE;
      cnt    <= '0;
      sreg   <= '0;
      byte_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        FR_IDLE: begin
          cnt <= '0;
          if (fall_i && !dat_i) st <= FR_SHIFT;
        end
        FR_SHIFT: begin
          if (fall_i) begin
            if (cnt == LAST) begin
              done_q <= 1'b1;
              byte_q <= sreg[CODE_W-1:0];
              st     <= FR_IDLE;
            end else begin
              sreg <= {dat_i, sreg[PAYLOAD-1:1]};
              cnt  <= cnt + 1'b1;
            end
          end
        end
        default: st <= FR_IDLE;
      endcase
    end
  end

  assign byte_o = byte_q;
  assign done_o = done_q;
endmodule

// File: rtl/kbd_make_filter.sv
module kbd_make_filter
  import kbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [CODE_W-1:0] byte_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              brk_o
);
  logic [CODE_W-1:0] code_q;
  logic              valid_q;
  logic              brk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      valid_q <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (done_i) begin
        case (classify_byte(byte_i))
          BYTE_RELEASE: brk_q <= 1'b1;
          BYTE_EXTEND:  brk_q <= brk_q;
          default: begin
            if (brk_q) begin
              brk_q <= 1'b0;
            end else begin
              code_q  <= byte_i;
              valid_q <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;
  assign brk_o   = brk_q;
endmodule

// File: rtl/kbd_keypress_decoder.sv
module kbd_keypress_decoder
  import kbd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8,
  parameter int PAYLOAD     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kb_clk_in,
  input  logic              kb_dat_in,
  output logic [CODE_W-1:0] key_code,
  output logic              key_valid
);
  logic              clk_synced;
  logic              dat_synced;
  logic              filt_clk;
  logic              fall_evt;
  logic              frame_done;
  logic [CODE_W-1:0] frame_byte;
  logic              brk_pending;

  kbd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_clk_sync (
    .clk(clk), .rst(rst), .din(kb_clk_in), .dout(clk_synced)
  );

  kbd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dat_sync (
    .clk(clk), .rst(rst), .din(kb_dat_in), .dout(dat_synced)
  );

  kbd_clk_filter #(.LEN(FILT_LEN)) u_filter (
    .clk(clk), .rst(rst), .raw_i(clk_synced),
    .filt_o(filt_clk), .fall_o(fall_evt)
  );

  kbd_frame_rx #(.PAYLOAD(PAYLOAD)) u_rx (
    .clk(clk), .rst(rst), .fall_i(fall_evt), .dat_i(dat_synced),
    .byte_o(frame_byte), .done_o(frame_done)
  );

  kbd_make_filter u_make (
    .clk(clk), .rst(rst), .done_i(frame_done), .byte_i(frame_byte),
    .code_o(key_code), .valid_o(key_valid), .brk_o(brk_pending)
  );
endmodule

// File: rtl/kbd_keypress_checker.sv
module kbd_keypress_checker (
  input logic       clk,
  input logic       rst,
  input logic       filt_clk,
  input logic       fall_evt,
  input logic       frame_done,
  input logic       brk_pending,
  input logic [7:0] key_code,
  input logic       key_valid
);
  assert_evt_filtered_low_R1: assert property (@(posedge clk) disable iff (rst)
    fall_evt |-> !filt_clk);

  assert_evt_isolated_R1: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> !fall_evt);

  assert_done_on_event_R3: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(fall_evt));

  assert_valid_after_done_R3: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> $past(frame_done));

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  assert_code_held_R4: assert property (@(posedge clk) disable iff (rst)
    !key_valid |-> $stable(key_code));

  assert_no_prefix_out_R6: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> (key_code != 8'hF0 && key_code != 8'hE0));

  assert_break_clear_R7: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> !brk_pending);
endmodule

bind kbd_keypress_decoder kbd_keypress_checker u_chk (
  .clk(clk), .rst(rst), .filt_clk(filt_clk), .fall_evt(fall_evt),
  .frame_done(frame_done), .brk_pending(brk_pending),
  .key_code(key_code), .key_valid(key_valid)
);

// File: tb/kbd_keypress_decoder_tb.sv
module kbd_keypress_decoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kb_clk = 1'b1;
  logic       kb_dat = 1'b1;
  logic [7:0] key_code;
  logic       key_valid;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [7:0] expq[$];
  string      tagq[$];

  logic kb_clk_prev = 1'b1;
  int   since_fall  = 1000;
  logic valid_prev  = 1'b0;

  always #10 clk = ~clk;

  kbd_keypress_decoder u_dut (
    .clk(clk), .rst(rst), .kb_clk_in(kb_clk), .kb_dat_in(kb_dat),
    .key_code(key_code), .key_valid(key_valid)
  );

  always @(posedge clk) begin
    kb_clk_prev <= kb_clk;
    if (kb_clk_prev && !kb_clk) since_fall <= 0;
    else if (since_fall < 1000) since_fall <= since_fall + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && key_valid) begin
      check(!valid_prev, "R4", "strobe wider than one cycle", 1, 0);
      check(since_fall <= 16, "R4", "strobe latency after stop edge",
            since_fall, 16);
      if (expq.size() == 0) begin
        check(1'b0, "R5", "unexpected report", key_code, 0);
      end else begin
        automatic logic [7:0] e = expq.pop_front();
        automatic string t = tagq.pop_front();
        check(key_code == e, t, "reported code", key_code, e);
      end
    end
    valid_prev <= key_valid;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(input logic b, input bit glitch);
    kb_dat = b;
    wait_cyc(20);
    kb_clk = 1'b0;
    wait_cyc(40);
    kb_clk = 1'b1;
    if (glitch) begin
      wait_cyc(6);
      kb_clk = 1'b0;
      wait_cyc(5);
      kb_clk = 1'b1;
      wait_cyc(9);
    end else begin
      wait_cyc(20);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit expect_it,
                           input string tag, input bit glitch = 1'b0);
    if (expect_it) begin
      expq.push_back(b);
      tagq.push_back(tag);
    end
    drive_bit(1'b0, glitch);
    for (int i = 0; i < 8; i++) drive_bit(b[i], glitch);
    drive_bit(~^b, glitch);
    drive_bit(1'b1, glitch);
    kb_dat = 1'b1;
  endtask

  task automatic drain(input string tag);
    wait_cyc(60);
    check(expq.size() == 0, tag, "pending expected reports", expq.size(), 0);
    expq.delete();
    tagq.delete();
  endtask

  initial begin
    wait_cyc(5);
    check(key_valid == 1'b0, "R9", "valid during reset", key_valid, 0);
    check(key_code == 8'h00, "R9", "code during reset", key_code, 0);
    rst = 1'b0;
    wait_cyc(20);

    // R3: plain make codes
    send_byte(8'h1C, 1'b1, "R3");
    send_byte(8'h32, 1'b1, "R3");
    send_byte(8'hA5, 1'b1, "R3");
    drain("R3");

    // R5: release sequence suppressed
    send_byte(8'hF0, 1'b0, "R5");
    send_byte(8'h1C, 1'b0, "R5");
    drain("R5");

    // R7: marker consumes one byte only
    send_byte(8'hF0, 1'b0, "R7");
    send_byte(8'h1C, 1'b0, "R7");
    send_byte(8'h1C, 1'b1, "R7");
    drain("R7");

    // R6: extension prefix
    send_byte(8'hE0, 1'b0, "R6");
    send_byte(8'h75, 1'b1, "R6");
    send_byte(8'hE0, 1'b0, "R6");
    send_byte(8'hF0, 1'b0, "R6");
    send_byte(8'h75, 1'b0, "R6");
    send_byte(8'hE0, 1'b0, "R6");
    send_byte(8'h29, 1'b1, "R6");
    drain("R6");

    // R8: held key repeats
    send_byte(8'h23, 1'b1, "R8");
    send_byte(8'h23, 1'b1, "R8");
    send_byte(8'h23, 1'b1, "R8");
    drain("R8");

    // R1: short glitches in idle and inside a frame
    kb_clk = 1'b0; wait_cyc(5); kb_clk = 1'b1; wait_cyc(20);
    kb_dat = 1'b0;
    kb_clk = 1'b0; wait_cyc(4); kb_clk = 1'b1; wait_cyc(20);
    kb_dat = 1'b1;
    send_byte(8'h4B, 1'b1, "R1", 1'b1);
    drain("R1");

    // R2: idle falling edge with data high is not a start bit
    drive_bit(1'b1, 1'b0);
    send_byte(8'h5A, 1'b1, "R2");
    drain("R2");

    // R9: reset in the middle of a frame
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) drive_bit(1'b1, 1'b0);
    rst = 1'b1;
    wait_cyc(3);
    check(key_valid == 1'b0, "R9", "valid under mid-frame reset", key_valid, 0);
    check(key_code == 8'h00, "R9", "code cleared by reset", key_code, 0);
    rst = 1'b0;
    wait_cyc(20);
    send_byte(8'h2B, 1'b1, "R9");
    drain("R9");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule